// File: doc/BRIEF.md
# I2C Target Controller with 7/10-bit Addressing

This block is the target (slave) side of an I2C bus. It watches the open-drain SCL and SDA lines through synchronisers and finds START, repeated START and STOP conditions. It matches its own address, which is either a 7-bit address or a two-byte 10-bit address. Data bytes that the bus writes go through an internal shift register into a receive holding register. Bytes that the bus reads come from a single-byte transmit register that the local host loads. The pins are modelled as pull-low enables (`scl_oe`, `sda_oe`) plus the line values seen on the bus.

The controller pauses a transfer by holding SCL low. It does this before every byte it transmits, and also after every accepted receive byte when receive stretching is enabled. The line is let go only after the host raises the release control. Status outputs report address match, transfer direction, 10-bit match, receive-full, overflow, transmit-full and stretching. A one-cycle interrupt pulse marks each protocol event.

Top module: `i2c_target_ctl`

## Requirements
- R1: When `addr10_mode`=0, a first byte after START whose bits [7:1] equal `own_addr[6:0]` is acknowledged (SDA held low during the 9th clock). `addr_match` is then set and `dir_read` takes bit 0 of that byte. Any other first byte gets no acknowledge, and the controller ignores the bus until the next START or STOP.
- R2: When `addr10_mode`=1, a header byte of the form `11110`, `own_addr[9:8]`, 0 (MSB first) is acknowledged. A following byte equal to `own_addr[7:0]` is also acknowledged, and only then are `addr_match` and `addr10_hit` set. A mismatch in either byte is not acknowledged.
- R3: After a completed 10-bit match, a repeated START followed by the header with bit 0 = 1 is acknowledged and sets `dir_read`. The same header is not acknowledged when no 10-bit match has completed since the last STOP.
- R4: Every data byte written to a matched target is shifted in MSB first. When it completes, it is copied to `rx_data`, `rx_full` is set and the byte is acknowledged. A `rx_read` pulse clears `rx_full`.
- R5: If a data byte completes while `rx_full` is still set, `rx_ovf` is set, the byte is not acknowledged and `rx_data` keeps its old value. A `ovf_clr` pulse clears `rx_ovf`.
- R6: After a read-address match, SCL is held low and `stretching`=1. This lasts until the transmit register has been loaded (`tx_load`) and `clk_release` has been pulsed. Loading alone does not release SCL.
- R7: Transmit bytes go out MSB first. A master acknowledge leads to a new stretch before the next byte. A master non-acknowledge makes the controller release SDA and ignore the bus until START or STOP.
- R8: With `stretch_rx`=1, SCL is held low after each acknowledged data byte until `clk_release` is pulsed. It is not held after address bytes.
- R9: A STOP clears `addr_match`, `dir_read` and `addr10_hit`. `rx_data` and `rx_full` keep their values.
- R10: A START in the middle of a byte restarts address matching from the first bit.
- R11: `irq` is a one-cycle pulse for each event: address match, data byte stored, overflow, and master acknowledge sampled after a transmitted byte.
- R12: After reset the pull-low enables are released and all status outputs and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line value |
| sda_in | input | 1 | SDA line value |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | 10 | Own target address |
| addr10_mode | input | 1 | 1 selects 10-bit addressing |
| stretch_rx | input | 1 | Stretch after each accepted receive byte |
| tx_data | input | 8 | Byte for the transmit register |
| tx_load | input | 1 | Load pulse for the transmit register |
| clk_release | input | 1 | Set the SCL release control |
| rx_read | input | 1 | Host has taken `rx_data` |
| ovf_clr | input | 1 | Clear the overflow flag |
| rx_data | output | 8 | Receive holding register |
| rx_full | output | 1 | Holding register holds an unread byte |
| rx_ovf | output | 1 | Receive overflow flag |
| tx_full | output | 1 | Transmit register loaded, not yet sent |
| addr_match | output | 1 | Own address matched |
| dir_read | output | 1 | Matched transfer is a bus read |
| addr10_hit | output | 1 | 10-bit address matched |
| stretching | output | 1 | Controller is holding SCL low |
| irq | output | 1 | Event pulse |

## Verification
The bench builds the block with `SYNC_STAGES`=3 and `ADDR10_EN`=1. The 10-bit matching path is therefore present, including the header-only read after a repeated START. The three-stage synchroniser adds input latency relative to the bit half-period, which tests that SDA changes made by the controller stay inside the SCL low phase and are never seen as a START or STOP. The stretch windows, the overflow NACK and a START in mid-byte are all reached at these values.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 10;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [4:0] HDR10 = 5'b11110;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RECV, ST_AACK, ST_SEND, ST_MACK, ST_HOLD, ST_WAIT
   } tgt_state_e;

   typedef enum logic [1:0] {
      K_HEAD, K_LOW, K_DATA
   } byte_kind_e;

   typedef struct packed {
      logic ack;
      logic addr_done;
      logic rd;
      logic hit10;
      logic to_low;
      logic store;
      logic ovf;
   } verdict_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[g] <= 1'b1;
               sda_pipe[g] <= 1'b1;
            end else begin
               scl_pipe[g] <= scl_in;
               sda_pipe[g] <= sda_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[g] <= 1'b1;
               sda_pipe[g] <= 1'b1;
            end else begin
               scl_pipe[g] <= scl_pipe[g-1];
               sda_pipe[g] <= sda_pipe[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_pipe[STAGES-1];
         sda_d <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s    = scl_pipe[STAGES-1];
   assign sda_s    = sda_pipe[STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
   import i2c_tgt_pkg::*;
#(
   parameter bit ADDR10_EN = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_v,
   input  byte_kind_e        kind,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              mode10,
   input  logic              hit10_q,
   input  logic              rx_full,
   output verdict_t          verd
);
   logic mode10_eff;

   if (ADDR10_EN) begin : g_ten
      assign mode10_eff = mode10;
   end else begin : g_seven
      assign mode10_eff = 1'b0;
   end

   always_comb begin
      verd = '0;
      case (kind)
         K_HEAD: begin
            if (mode10_eff) begin
               if (byte_v[7:3] == HDR10 && byte_v[2:1] == own_addr[9:8]) begin
                  if (!byte_v[0]) begin
                     verd.ack    = 1'b1;
                     verd.to_low = 1'b1;
                  end else if (hit10_q) begin
                     verd.ack       = 1'b1;
                     verd.addr_done = 1'b1;
                     verd.rd        = 1'b1;
                     verd.hit10     = 1'b1;
                  end
               end
            end else if (byte_v[7:1] == own_addr[6:0]) begin
               verd.ack       = 1'b1;
               verd.addr_done = 1'b1;
               verd.rd        = byte_v[0];
            end
         end
         K_LOW: begin
            if (byte_v == own_addr[7:0]) begin
               verd.ack       = 1'b1;
               verd.addr_done = 1'b1;
               verd.hit10     = 1'b1;
            end
         end
         K_DATA: begin
            if (rx_full) begin
               verd.ovf = 1'b1;
            end else begin
               verd.ack   = 1'b1;
               verd.store = 1'b1;
            end
         end
         default: verd = '0;
      endcase
   end
endmodule

// File: rtl/i2c_tgt_rxbuf.sv
module i2c_tgt_rxbuf
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store,
   input  logic              ovf_set,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              rd_ack,
   input  logic              ovf_clr,
   output logic [BYTE_W-1:0] hold_q,
   output logic              full_q,
   output logic              ovf_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (store) begin
            hold_q <= byte_in;
            full_q <= 1'b1;
         end else if (rd_ack) begin
            full_q <= 1'b0;
         end
         if (ovf_set) begin
            ovf_q <= 1'b1;
         end else if (ovf_clr) begin
            ovf_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/i2c_target_ctl.sv
module i2c_target_ctl
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit ADDR10_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              addr10_mode,
   input  logic              stretch_rx,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_load,
   input  logic              clk_release,
   input  logic              rx_read,
   input  logic              ovf_clr,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_ovf,
   output logic              tx_full,
   output logic              addr_match,
   output logic              dir_read,
   output logic              addr10_hit,
   output logic              stretching,
   output logic              irq
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_target_ctl: SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

   tgt_state_e        state_q;
   byte_kind_e        kind_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [BYTE_W-1:0] tx_q;
   logic [BYTE_W-1:0] byte_now;
   verdict_t          verd, verd_q;
   logic              hold_tx_q, rel_q, tx_full_q, mack_q;
   logic              sda_oe_q, scl_oe_q, match_q, dir_q, hit10_q, irq_q;
   logic              byte_done;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   assign byte_now  = {shreg_q[BYTE_W-2:0], sda_s};
   assign byte_done = (state_q == ST_RECV) && scl_rise && (cnt_q == CNT_LAST);

   i2c_tgt_match #(.ADDR10_EN(ADDR10_EN)) u_match (
      .byte_v   (byte_now),
      .kind     (kind_q),
      .own_addr (own_addr),
      .mode10   (addr10_mode),
      .hit10_q  (hit10_q),
      .rx_full  (rx_full),
      .verd     (verd)
   );

   i2c_tgt_rxbuf u_rxbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .store   (byte_done && verd.store),
      .ovf_set (byte_done && verd.ovf),
      .byte_in (byte_now),
      .rd_ack  (rx_read),
      .ovf_clr (ovf_clr),
      .hold_q  (rx_data),
      .full_q  (rx_full),
      .ovf_q   (rx_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= K_HEAD;
         cnt_q     <= '0;
         shreg_q   <= '0;
         tx_q      <= '0;
         verd_q    <= '0;
         hold_tx_q <= 1'b0;
         rel_q     <= 1'b0;
         tx_full_q <= 1'b0;
         mack_q    <= 1'b0;
         sda_oe_q  <= 1'b0;
         scl_oe_q  <= 1'b0;
         match_q   <= 1'b0;
         dir_q     <= 1'b0;
         hit10_q   <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (clk_release) rel_q <= 1'b1;
         if (tx_load) begin
            tx_q      <= tx_data;
            tx_full_q <= 1'b1;
         end
         if (stop_ev) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sda_oe_q <= 1'b0;
            scl_oe_q <= 1'b0;
            match_q  <= 1'b0;
            dir_q    <= 1'b0;
            hit10_q  <= 1'b0;
         end else if (start_ev) begin
            state_q  <= ST_RECV;
            kind_q   <= K_HEAD;
            cnt_q    <= '0;
            sda_oe_q <= 1'b0;
            scl_oe_q <= 1'b0;
            match_q  <= 1'b0;
            dir_q    <= 1'b0;
         end else begin
            case (state_q)
               ST_RECV: begin
                  if (scl_rise && cnt_q < CNT_FULL) begin
                     shreg_q <= byte_now;
                     cnt_q   <= cnt_q + 1'b1;
                  end
                  if (byte_done) begin
                     verd_q <= verd;
                     irq_q  <= verd.addr_done | verd.store | verd.ovf;
                     if (verd.addr_done) begin
                        match_q <= 1'b1;
                        dir_q   <= verd.rd;
                        if (verd.hit10) hit10_q <= 1'b1;
                     end
                  end
                  if (scl_fall && cnt_q == CNT_FULL) begin
                     if (verd_q.ack) begin
                        sda_oe_q <= 1'b1;
                        state_q  <= ST_AACK;
                     end else begin
                        state_q  <= ST_WAIT;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     sda_oe_q <= 1'b0;
                     cnt_q    <= '0;
                     if (verd_q.to_low) begin
                        state_q <= ST_RECV;
                        kind_q  <= K_LOW;
                     end else if (verd_q.addr_done && verd_q.rd) begin
                        state_q   <= ST_HOLD;
                        hold_tx_q <= 1'b1;
                        scl_oe_q  <= 1'b1;
                        rel_q     <= 1'b0;
                     end else if (verd_q.store && stretch_rx) begin
                        state_q   <= ST_HOLD;
                        hold_tx_q <= 1'b0;
                        scl_oe_q  <= 1'b1;
                        rel_q     <= 1'b0;
                     end else begin
                        state_q <= ST_RECV;
                        kind_q  <= K_DATA;
                     end
                  end
               end
               ST_HOLD: begin
                  if (hold_tx_q) begin
                     if (rel_q && tx_full_q) begin
                        shreg_q   <= tx_q;
                        tx_full_q <= 1'b0;
                        sda_oe_q  <= ~tx_q[BYTE_W-1];
                        cnt_q     <= CNT_W'(1);
                        rel_q     <= 1'b0;
                        state_q   <= ST_SEND;
                     end
                  end else if (rel_q) begin
                     scl_oe_q <= 1'b0;
                     rel_q    <= 1'b0;
                     cnt_q    <= '0;
                     kind_q   <= K_DATA;
                     state_q  <= ST_RECV;
                  end
               end
               ST_SEND: begin
                  scl_oe_q <= 1'b0;
                  if (scl_fall) begin
                     if (cnt_q == CNT_FULL) begin
                        sda_oe_q <= 1'b0;
                        state_q  <= ST_MACK;
                     end else begin
                        shreg_q  <= shreg_q << 1;
                        sda_oe_q <= ~shreg_q[BYTE_W-2];
                        cnt_q    <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                     irq_q  <= 1'b1;
                  end
                  if (scl_fall) begin
                     if (mack_q) begin
                        state_q   <= ST_HOLD;
                        hold_tx_q <= 1'b1;
                        scl_oe_q  <= 1'b1;
                        rel_q     <= 1'b0;
                     end else begin
                        state_q <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign scl_oe     = scl_oe_q;
   assign sda_oe     = sda_oe_q;
   assign tx_full    = tx_full_q;
   assign addr_match = match_q;
   assign dir_read   = dir_q;
   assign addr10_hit = hit10_q;
   assign stretching = (state_q == ST_HOLD);
   assign irq        = irq_q;
endmodule

// File: rtl/i2c_target_ctl_chk.sv
module i2c_target_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_oe,
   input logic       addr10_mode,
   input logic [7:0] rx_data,
   input logic       rx_full,
   input logic       rx_ovf,
   input logic       addr_match,
   input logic       dir_read,
   input logic       addr10_hit,
   input logic       stretching,
   input logic       irq,
   input logic       stop_ev
);
   assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_store_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> irq);

   assert_ovf_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovf) |-> ($stable(rx_data) && rx_full));

   assert_stretch_drives_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stretching |-> scl_oe);

   assert_hit10_needs_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr10_hit) |-> (addr10_mode && addr_match));

   assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (!addr_match && !addr10_hit && !dir_read));
endmodule

bind i2c_target_ctl i2c_target_ctl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_oe      (scl_oe),
   .addr10_mode (addr10_mode),
   .rx_data     (rx_data),
   .rx_full     (rx_full),
   .rx_ovf      (rx_ovf),
   .addr_match  (addr_match),
   .dir_read    (dir_read),
   .addr10_hit  (addr10_hit),
   .stretching  (stretching),
   .irq         (irq),
   .stop_ev     (stop_ev)
);

// File: tb/i2c_target_ctl_test.sv
module i2c_target_ctl_test;
   localparam int HP = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl_low = 1'b0;
   logic       m_sda_low = 1'b0;
   logic       scl_bus, sda_bus;
   logic       scl_oe, sda_oe;
   logic [9:0] own_addr = '0;
   logic       addr10_mode = 1'b0;
   logic       stretch_rx = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_load = 1'b0;
   logic       clk_release = 1'b0;
   logic       rx_read = 1'b0;
   logic       ovf_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, rx_ovf, tx_full, addr_match, dir_read, addr10_hit, stretching, irq;

   int n_cmp = 0;
   int n_bad = 0;
   int irq_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign scl_bus = !(m_scl_low || scl_oe);
   assign sda_bus = !(m_sda_low || sda_oe);

   always @(posedge clk) if (rst_n && irq) irq_cnt++;

   i2c_target_ctl #(.SYNC_STAGES(3), .ADDR10_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
      .addr10_mode(addr10_mode), .stretch_rx(stretch_rx), .tx_data(tx_data),
      .tx_load(tx_load), .clk_release(clk_release), .rx_read(rx_read),
      .ovf_clr(ovf_clr), .rx_data(rx_data), .rx_full(rx_full), .rx_ovf(rx_ovf),
      .tx_full(tx_full), .addr_match(addr_match), .dir_read(dir_read),
      .addr10_hit(addr10_hit), .stretching(stretching), .irq(irq)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic logic [7:0] hdr10(input logic [9:0] a, input logic rw);
      return {5'b11110, a[9:8], rw};
   endfunction

   function automatic logic [7:0] other_byte(input logic [7:0] b);
      return b ^ (8'h01 << ($urandom % 8));
   endfunction

   task automatic hp();
      repeat (HP) @(negedge clk);
   endtask

   task automatic pulse_read();
      rx_read = 1'b1; @(negedge clk); rx_read = 1'b0; @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic s);
      m_sda_low = !b;
      hp();
      m_scl_low = 1'b0;
      wait (scl_bus == 1'b1);
      hp();
      s = sda_bus;
      m_scl_low = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0;
      hp();
      m_scl_low = 1'b0;
      wait (scl_bus == 1'b1);
      hp();
      m_sda_low = 1'b1;
      hp();
      m_scl_low = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1;
      hp();
      m_scl_low = 1'b0;
      wait (scl_bus == 1'b1);
      hp();
      m_sda_low = 1'b0;
      hp(); hp();
   endtask

   task automatic write_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic read_byte(input logic mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      clk_bit(!mack, s);
   endtask

   task automatic host_feed(input logic [7:0] b);
      wait (stretching == 1'b1);
      repeat (6) @(negedge clk);
      chk("R6 scl held low while stretching", {31'd0, scl_bus}, 32'd0);
      tx_data = b; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
      repeat (10) @(negedge clk);
      chk("R6 load without release keeps stretch", {31'd0, stretching}, 32'd1);
      chk("R6 tx_full after load", {31'd0, tx_full}, 32'd1);
      clk_release = 1'b1; @(negedge clk); clk_release = 1'b0;
   endtask

   task automatic host_release();
      wait (stretching == 1'b1);
      repeat (8) @(negedge clk);
      clk_release = 1'b1; @(negedge clk); clk_release = 1'b0;
   endtask

   task automatic read_one(input logic [7:0] b, input logic mack);
      logic [7:0] d;
      fork
         read_byte(mack, d);
         host_feed(b);
      join
      chk("R7 transmitted byte", {24'd0, d}, {24'd0, b});
   endtask

   task automatic write_data_ok(input logic [7:0] b);
      logic ack;
      write_byte(b, ack);
      chk("R4 data ack", {31'd0, ack}, 32'd1);
      chk("R4 rx_data", {24'd0, rx_data}, {24'd0, b});
      chk("R4 rx_full set", {31'd0, rx_full}, 32'd1);
      pulse_read();
      chk("R4 rx_full cleared", {31'd0, rx_full}, 32'd0);
   endtask

   task automatic ten_bit_addr(input logic [9:0] a);
      logic ack;
      write_byte(hdr10(a, 1'b0), ack);
      chk("R2 header ack", {31'd0, ack}, 32'd1);
      chk("R2 no match after header only", {31'd0, addr_match}, 32'd0);
      write_byte(a[7:0], ack);
      chk("R2 low byte ack", {31'd0, ack}, 32'd1);
      chk("R2 match flags", {30'd0, addr_match, addr10_hit}, 32'd3);
   endtask

   initial begin
      logic       ack;
      logic       s;
      logic [7:0] b, b2;
      int         base, n, mode;
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R12 reset outputs",
          {23'd0, scl_oe, sda_oe, rx_full, rx_ovf, tx_full, addr_match, dir_read, addr10_hit, irq},
          32'd0);
      chk("R12 reset stretching", {31'd0, stretching}, 32'd0);

      // 7-bit write with random data
      own_addr = 10'($urandom);
      base = irq_cnt;
      bus_start();
      write_byte({own_addr[6:0], 1'b0}, ack);
      chk("R1 7-bit address ack", {31'd0, ack}, 32'd1);
      chk("R1 match and write dir", {30'd0, addr_match, dir_read}, 32'd2);
      for (int i = 0; i < 3; i++) write_data_ok(8'($urandom));
      b = 8'($urandom);
      write_byte(b, ack);
      bus_stop();
      chk("R9 stop clears match", {31'd0, addr_match}, 32'd0);
      chk("R9 stop keeps rx data", {23'd0, rx_full, rx_data}, {23'd0, 1'b1, b});
      chk("R11 irq count 7-bit write", irq_cnt - base, 32'd5);
      pulse_read();

      // 7-bit mismatch: ignored until next START
      bus_start();
      write_byte({own_addr[6:0] ^ 7'h11, 1'b0}, ack);
      chk("R1 mismatch nack", {31'd0, ack}, 32'd0);
      write_byte(8'h5a, ack);
      chk("R1 ignored after mismatch", {29'd0, ack, addr_match, rx_full}, 32'd0);
      bus_stop();

      // overflow
      base = irq_cnt;
      bus_start();
      write_byte({own_addr[6:0], 1'b0}, ack);
      b = 8'($urandom);
      write_byte(b, ack);
      b2 = ~b;
      write_byte(b2, ack);
      chk("R5 overflow nack", {31'd0, ack}, 32'd0);
      chk("R5 overflow flag and data kept", {23'd0, rx_ovf, rx_data}, {23'd0, 1'b1, b});
      chk("R11 irq count overflow", irq_cnt - base, 32'd3);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
      chk("R5 ovf_clr", {31'd0, rx_ovf}, 32'd0);
      pulse_read();
      bus_stop();

      // 7-bit read with stretching
      base = irq_cnt;
      bus_start();
      write_byte({own_addr[6:0], 1'b1}, ack);
      chk("R1 read address ack and dir", {30'd0, ack, dir_read}, 32'd3);
      read_one(8'($urandom), 1'b1);
      read_one(8'($urandom), 1'b1);
      read_one(8'($urandom), 1'b0);
      repeat (10) @(negedge clk);
      chk("R7 sda released after master nack", {30'd0, sda_oe, stretching}, 32'd0);
      bus_stop();
      chk("R11 irq count read", irq_cnt - base, 32'd4);

      // 10-bit write then repeated START read
      addr10_mode = 1'b1;
      own_addr = 10'($urandom);
      bus_start();
      ten_bit_addr(own_addr);
      write_data_ok(8'($urandom));
      bus_start();
      write_byte(hdr10(own_addr, 1'b1), ack);
      chk("R3 10-bit read header ack", {31'd0, ack}, 32'd1);
      chk("R3 read dir and hit kept", {30'd0, dir_read, addr10_hit}, 32'd3);
      read_one(8'($urandom), 1'b0);
      bus_stop();
      chk("R9 stop clears 10-bit hit", {30'd0, addr10_hit, dir_read}, 32'd0);

      // 10-bit header mismatch
      bus_start();
      write_byte({5'b11110, own_addr[9:8] ^ 2'b01, 1'b0}, ack);
      chk("R2 header mismatch nack", {31'd0, ack}, 32'd0);
      bus_stop();

      // 10-bit low byte mismatch
      bus_start();
      write_byte(hdr10(own_addr, 1'b0), ack);
      write_byte(other_byte(own_addr[7:0]), ack);
      chk("R2 low byte mismatch nack", {29'd0, ack, addr_match, addr10_hit}, 32'd0);
      bus_stop();

      // read header without prior 10-bit match
      bus_start();
      write_byte(hdr10(own_addr, 1'b1), ack);
      chk("R3 read header without match nack", {31'd0, ack}, 32'd0);
      bus_stop();

      // START in mid-byte
      addr10_mode = 1'b0;
      bus_start();
      for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
      bus_start();
      write_byte({own_addr[6:0], 1'b0}, ack);
      chk("R10 restart then address ack", {30'd0, ack, addr_match}, 32'd3);
      bus_stop();

      // receive stretching
      stretch_rx = 1'b1;
      bus_start();
      write_byte({own_addr[6:0], 1'b0}, ack);
      repeat (HP) @(negedge clk);
      chk("R8 no stretch after address", {31'd0, stretching}, 32'd0);
      b = 8'($urandom);
      write_byte(b, ack);
      repeat (20) @(negedge clk);
      chk("R8 stretch after data byte", {30'd0, stretching, scl_bus}, 32'd2);
      chk("R8 byte stored during stretch", {24'd0, rx_data}, {24'd0, b});
      pulse_read();
      b2 = 8'($urandom);
      fork
         write_byte(b2, ack);
         host_release();
      join
      chk("R8 byte after release", {23'd0, ack, rx_data}, {23'd0, 1'b1, b2});
      pulse_read();
      fork
         bus_stop();
         host_release();
      join
      stretch_rx = 1'b0;

      // constrained random transactions
      for (int t = 0; t < 8; t++) begin
         mode = $urandom % 3;
         n = 1 + ($urandom % 3);
         own_addr = 10'($urandom);
         addr10_mode = (mode == 1);
         repeat (4) @(negedge clk);
         base = irq_cnt;
         bus_start();
         if (mode == 1) begin
            ten_bit_addr(own_addr);
         end else begin
            write_byte({own_addr[6:0], mode == 2}, ack);
            chk("R1 random address ack", {31'd0, ack}, 32'd1);
         end
         for (int k = 0; k < n; k++) begin
            if (mode == 2) read_one(8'($urandom), k != n - 1);
            else write_data_ok(8'($urandom));
         end
         bus_stop();
         chk("R11 random irq count", irq_cnt - base, 32'(n + 1));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R12: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule